// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block sits between the reset sources of a small CPU subsystem and the logic those sources reset. It watches three causes: an external power-on reset pin, a single-cycle watchdog overflow event, and an external manual reset pin. It turns them into three separate active-low reset enables, one each for the CPU core, the on-chip peripherals and the pin-function/I/O-port registers. The domains it asserts depend on the cause.

Both pins pass through a two-flop synchronizer before any decision is made. The synchronized power-on pin also serves as the block's own synchronous reset.

- **Power-on pin:** clears everything, including the watchdog status flag.
- **Watchdog overflow:** honoured only when the watchdog is configured to cause a power-on reset. It resets the core and the peripherals but leaves the port registers alone. It also sets a status flag that the reset does not clear; software clears it with a write strobe.
- **Manual reset pin:** counts only after it has stayed low for a minimum time. That time is 20 cycles with the clock running, or a programmable count in standby mode. Entry is deferred while a bus cycle is in progress. Manual reset touches only the CPU core.

When any reset ends, the block raises a one-cycle start pulse for the exception sequencer and presents a 2-bit code giving the reset type.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While the synchronized power-on pin is low, cpu_rst_n, periph_rst_n and port_rst_n are all low and start is low. After the pin rises, exactly one start pulse follows with rst_kind = 2'b00.
- R2: A wdt_ovf pulse with wdt_por_en = 1 holds cpu_rst_n and periph_rst_n low for WDT_HOLD (default 8) cycles. port_rst_n stays high throughout. The block then gives one start pulse with rst_kind = 2'b01.
- R3: A wdt_ovf pulse with wdt_por_en = 0 has no effect on any reset output, on start or on wdt_flag.
- R4: A watchdog-caused reset sets wdt_flag. The flag stays set through that reset and afterwards, and a one-cycle flag_clr pulse clears it.
- R5: When the power-on pin and a watchdog overflow are active together, the power-on reset wins. All three domains are reset, wdt_flag reads 0, and the following start pulse carries rst_kind = 2'b00.
- R6: With standby = 0, a manual pin low period of at least 20 synchronized cycles is accepted. A shorter low period is ignored.
- R7: With standby = 1, the minimum manual low period is settle_cnt cycles instead of 20.
- R8: While bus_busy is high, manual reset entry is deferred. If the pin returns high before the bus goes idle, the request is dropped.
- R9: During a manual reset only cpu_rst_n is low; periph_rst_n and port_rst_n stay high.
- R10: A manual reset ends when the manual pin returns high, with one start pulse and rst_kind = 2'b10.
- R11: start is never high two cycles in a row, and rst_kind changes only in a cycle where start is high.
- R12: A watchdog overflow (wdt_por_en = 1) during a manual reset turns it into a watchdog reset. The peripherals are then reset too, and the block reports rst_kind = 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subsystem clock |
| por_pin_n | input | 1 | External power-on reset pin, active low, asynchronous |
| mrst_pin_n | input | 1 | External manual reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow event, one-cycle pulse |
| wdt_por_en | input | 1 | Watchdog configured to cause a power-on reset |
| bus_busy | input | 1 | High while a bus cycle is in progress |
| standby | input | 1 | Selects settle_cnt as the manual minimum low time |
| settle_cnt | input | CNT_W | Minimum manual low cycles in standby mode |
| flag_clr | input | 1 | Write strobe that clears the watchdog flag |
| wdt_flag | output | 1 | Watchdog-reset status flag |
| cpu_rst_n | output | 1 | CPU core reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| port_rst_n | output | 1 | Pin-function and I/O-port register reset, active low |
| start | output | 1 | One-cycle pulse when a reset ends |
| rst_kind | output | 2 | Cause of the last reset: 00 pin power-on, 01 watchdog, 10 manual |

## Verification
The embedded assertions check the following on every cycle:
- a watchdog reset spares the port domain and sets the flag;
- a manual reset touches only the core;
- a busy bus blocks manual entry;
- start is a single-cycle pulse, and the type code is stable between pulses.

Other behaviours depend on histories longer than a few cycles, so only the bench scenarios can show them:
- the exact length of the accepted manual pulse in both running and standby mode;
- a request dropped because the bus stayed busy until the pin rose;
- the flag surviving its own reset and being cleared by a simultaneous pin reset;
- the conversion of a manual reset into a watchdog reset.

// File: rtl/rst_pkg.sv
// Shared types for the reset controller: sequencer state and reset-cause code.
package rst_pkg;

    typedef enum logic [1:0] {
        ST_POR = 2'd0,
        ST_RUN = 2'd1,
        ST_WDT = 2'd2,
        ST_MAN = 2'd3
    } seq_st_t;

    typedef enum logic [1:0] {
        KIND_EXT = 2'b00,
        KIND_WDT = 2'b01,
        KIND_MAN = 2'b10
    } rst_kind_t;

endpackage

// File: rtl/pin_sync.sv
// Multi-bit, multi-stage synchronizer for asynchronous pin inputs.
// Assumes each bit is an independent level signal. The flops carry no reset,
// because the power-on pin itself passes through this chain.
module pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw pin level through the flop chain.
        always_ff @(posedge clk) begin
            chain <= {chain[STAGES-2:0], pin_in[b]};
        end

        assign pin_sync_out[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/mrst_qual.sv
// Qualifies the synchronized manual reset pin against a minimum low time.
// valid is high while the pin is low and has been low for at least the
// required number of cycles, the current cycle included. Assumes the pin
// input is already synchronized. Synchronous active-low reset.
module mrst_qual #(
    parameter int MIN_LOW = 20,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mrst_s,
    input  logic             standby,
    input  logic [CNT_W-1:0] settle_cnt,
    output logic             valid
);

    localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(MIN_LOW);

    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W:0]   seen;
    logic [CNT_W-1:0] need;

    // Count consecutive low cycles, saturating at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n || mrst_s) begin
            low_cnt <= '0;
        end else if (low_cnt != '1) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Compare the low time, current cycle included, against the selected minimum.
    always_comb begin
        need  = standby ? settle_cnt : MIN_VAL;
        seen  = {1'b0, low_cnt} + 1'b1;
        valid = !mrst_s && (seen >= {1'b0, need});
    end

    // R6: a request is never valid in the first low cycle when the minimum exceeds one.
    p_no_instant_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby && $fell(mrst_s)) |-> !valid);

endmodule

// File: rtl/rst_seq.sv
// Reset sequencer: arbitrates the causes, drives the per-domain reset enables,
// keeps the watchdog flag and reports the reset type on release.
// Priority: power-on pin (synchronous reset) > watchdog > manual.
// Assumes mq_valid already contains the minimum-low-time qualification.
module rst_seq
    import rst_pkg::*;
#(
    parameter int WDT_HOLD = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mrst_s,
    input  logic      mq_valid,
    input  logic      wdt_ovf,
    input  logic      wdt_por_en,
    input  logic      bus_busy,
    input  logic      flag_clr,
    output logic      wdt_flag,
    output logic      cpu_rst_n,
    output logic      periph_rst_n,
    output logic      port_rst_n,
    output logic      start,
    output rst_kind_t kind
);

    localparam int               HOLD_W    = (WDT_HOLD > 1) ? $clog2(WDT_HOLD) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(WDT_HOLD - 1);

    seq_st_t           st;
    logic [HOLD_W-1:0] hold;
    logic              wdt_take;

    // A watchdog overflow counts only when configured and not already in a power-on class reset.
    assign wdt_take = wdt_ovf && wdt_por_en && (st == ST_RUN || st == ST_MAN);

    // Main state, hold counter, start pulse and reset-type register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_POR;
            hold  <= '0;
            start <= 1'b0;
            kind  <= KIND_EXT;
        end else begin
            start <= 1'b0;
            case (st)
                ST_POR: begin
                    st    <= ST_RUN;
                    start <= 1'b1;
                    kind  <= KIND_EXT;
                end
                ST_RUN: begin
                    if (wdt_take) begin
                        st   <= ST_WDT;
                        hold <= '0;
                    end else if (mq_valid && !bus_busy) begin
                        st <= ST_MAN;
                    end
                end
                ST_MAN: begin
                    if (wdt_take) begin
                        st   <= ST_WDT;
                        hold <= '0;
                    end else if (mrst_s) begin
                        st    <= ST_RUN;
                        start <= 1'b1;
                        kind  <= KIND_MAN;
                    end
                end
                ST_WDT: begin
                    if (hold == HOLD_LAST) begin
                        st    <= ST_RUN;
                        start <= 1'b1;
                        kind  <= KIND_WDT;
                    end else begin
                        hold <= hold + 1'b1;
                    end
                end
                default: st <= ST_POR;
            endcase
        end
    end

    // Watchdog flag: set by a taken overflow, cleared by the strobe or the pin reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_flag <= 1'b0;
        end else if (wdt_take) begin
            wdt_flag <= 1'b1;
        end else if (flag_clr) begin
            wdt_flag <= 1'b0;
        end
    end

    // Per-domain reset enables decoded from the state.
    always_comb begin
        cpu_rst_n    = (st == ST_RUN);
        periph_rst_n = !(st == ST_POR || st == ST_WDT);
        port_rst_n   = (st != ST_POR);
    end

    // R2: a watchdog reset resets core and peripherals but never the port registers.
    p_wdt_spares_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_take |=> (!cpu_rst_n && !periph_rst_n && port_rst_n));

    // R3: an unconfigured overflow never starts a watchdog reset.
    p_wdt_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && wdt_ovf && !wdt_por_en) |=> periph_rst_n);

    // R4: a taken overflow leaves the flag set.
    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_take |=> wdt_flag);

    // R4: a clear strobe without a new overflow empties the flag.
    p_flag_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !wdt_take) |=> !wdt_flag);

    // R8: no manual entry while the bus is busy.
    p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && bus_busy) |=> (st != ST_MAN));

    // R9: a manual reset touches the core only.
    p_man_core_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MAN) |-> (!cpu_rst_n && periph_rst_n && port_rst_n));

    // R11: single-cycle start pulse.
    p_start_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R11: the type code moves only with a start pulse.
    p_kind_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> $stable(kind));

    // R12: an overflow during manual reset widens it to the peripherals.
    p_wdt_over_man_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MAN && wdt_ovf && wdt_por_en) |=> !periph_rst_n);

endmodule

// File: rtl/rst_cause_ctrl.sv
// Top of the multi-source reset controller: synchronizes the two reset pins,
// qualifies the manual pin and sequences the per-domain resets.
// Assumes wdt_ovf, wdt_por_en, bus_busy, standby, settle_cnt and flag_clr are
// already synchronous to clk. The synchronized power-on pin is the internal reset.
module rst_cause_ctrl
    import rst_pkg::*;
#(
    parameter int MIN_LOW  = 20,
    parameter int CNT_W    = 16,
    parameter int WDT_HOLD = 8,
    parameter int SYNC_STG = 2
) (
    input  logic             clk,
    input  logic             por_pin_n,
    input  logic             mrst_pin_n,
    input  logic             wdt_ovf,
    input  logic             wdt_por_en,
    input  logic             bus_busy,
    input  logic             standby,
    input  logic [CNT_W-1:0] settle_cnt,
    input  logic             flag_clr,
    output logic             wdt_flag,
    output logic             cpu_rst_n,
    output logic             periph_rst_n,
    output logic             port_rst_n,
    output logic             start,
    output logic [1:0]       rst_kind
);

    logic [1:0] pins_s;
    logic       por_s;
    logic       mrst_s;
    logic       mq_valid;
    rst_kind_t  kind;

    pin_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk          (clk),
        .pin_in       ({mrst_pin_n, por_pin_n}),
        .pin_sync_out (pins_s)
    );

    assign por_s  = pins_s[0];
    assign mrst_s = pins_s[1];

    mrst_qual #(
        .MIN_LOW (MIN_LOW),
        .CNT_W   (CNT_W)
    ) u_qual (
        .clk        (clk),
        .rst_n      (por_s),
        .mrst_s     (mrst_s),
        .standby    (standby),
        .settle_cnt (settle_cnt),
        .valid      (mq_valid)
    );

    rst_seq #(
        .WDT_HOLD (WDT_HOLD)
    ) u_seq (
        .clk          (clk),
        .rst_n        (por_s),
        .mrst_s       (mrst_s),
        .mq_valid     (mq_valid),
        .wdt_ovf      (wdt_ovf),
        .wdt_por_en   (wdt_por_en),
        .bus_busy     (bus_busy),
        .flag_clr     (flag_clr),
        .wdt_flag     (wdt_flag),
        .cpu_rst_n    (cpu_rst_n),
        .periph_rst_n (periph_rst_n),
        .port_rst_n   (port_rst_n),
        .start        (start),
        .kind         (kind)
    );

    assign rst_kind = kind;

    // R1: the port domain is only ever reset together with the other two.
    p_port_with_all_r1: assert property (@(posedge clk) disable iff (!por_s)
        !port_rst_n |-> (!cpu_rst_n && !periph_rst_n));

endmodule

// File: tb/test_rst_cause_ctrl.sv
// Self-checking bench: a vector table of manual-pin pulses, then directed tests.
module test_rst_cause_ctrl;

    localparam int HOLD = 8;

    logic        clk = 1'b0;
    logic        por_pin_n = 1'b0;
    logic        mrst_pin_n = 1'b1;
    logic        wdt_ovf = 1'b0;
    logic        wdt_por_en = 1'b0;
    logic        bus_busy = 1'b0;
    logic        standby = 1'b0;
    logic [15:0] settle_cnt = '0;
    logic        flag_clr = 1'b0;
    logic        wdt_flag, cpu_rst_n, periph_rst_n, port_rst_n, start;
    logic [1:0]  rst_kind;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Monitor counters, sampled at the falling edge.
    int n_cpu, n_per, n_port, n_start;
    logic [1:0] first_kind, last_kind;

    always #4 clk = ~clk;

    rst_cause_ctrl i_rst_cause_ctrl (
        .clk          (clk),
        .por_pin_n    (por_pin_n),
        .mrst_pin_n   (mrst_pin_n),
        .wdt_ovf      (wdt_ovf),
        .wdt_por_en   (wdt_por_en),
        .bus_busy     (bus_busy),
        .standby      (standby),
        .settle_cnt   (settle_cnt),
        .flag_clr     (flag_clr),
        .wdt_flag     (wdt_flag),
        .cpu_rst_n    (cpu_rst_n),
        .periph_rst_n (periph_rst_n),
        .port_rst_n   (port_rst_n),
        .start        (start),
        .rst_kind     (rst_kind)
    );

    always @(negedge clk) begin
        if (cpu_rst_n === 1'b0)    n_cpu++;
        if (periph_rst_n === 1'b0) n_per++;
        if (port_rst_n === 1'b0)   n_port++;
        if (start === 1'b1) begin
            if (n_start == 0) first_kind = rst_kind;
            last_kind = rst_kind;
            n_start++;
        end
    end

    task automatic clear_mon();
        n_cpu = 0; n_per = 0; n_port = 0; n_start = 0;
        first_kind = 2'b11; last_kind = 2'b11;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wdt();
        @(negedge clk); wdt_ovf = 1'b1;
        @(negedge clk); wdt_ovf = 1'b0;
    endtask

    typedef struct packed {
        logic [7:0]  low_len;
        logic [7:0]  busy_len;
        logic        stby;
        logic [15:0] scnt;
    } mvec_t;

    localparam mvec_t VECS [8] = '{
        '{low_len: 8'd20, busy_len: 8'd0,  stby: 1'b0, scnt: 16'd0},   // R6 boundary accepted
        '{low_len: 8'd19, busy_len: 8'd0,  stby: 1'b0, scnt: 16'd0},   // R6 one short
        '{low_len: 8'd30, busy_len: 8'd10, stby: 1'b0, scnt: 16'd0},   // R8 deferred then taken
        '{low_len: 8'd30, busy_len: 8'd40, stby: 1'b0, scnt: 16'd0},   // R8 dropped
        '{low_len: 8'd5,  busy_len: 8'd0,  stby: 1'b1, scnt: 16'd5},   // R7 boundary accepted
        '{low_len: 8'd4,  busy_len: 8'd0,  stby: 1'b1, scnt: 16'd5},   // R7 one short
        '{low_len: 8'd30, busy_len: 8'd0,  stby: 1'b1, scnt: 16'd40},  // R7 longer standby minimum
        '{low_len: 8'd3,  busy_len: 8'd0,  stby: 1'b0, scnt: 16'd0}    // R6 glitch
    };

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_mon();

        // R1: reset state while the pin is low.
        idle(6);
        check(cpu_rst_n == 1'b0 && periph_rst_n == 1'b0 && port_rst_n == 1'b0,
              "R1 domains in pin reset", {cpu_rst_n, periph_rst_n, port_rst_n}, 0);
        check(start == 1'b0 && wdt_flag == 1'b0, "R1 start/flag in reset", {start, wdt_flag}, 0);
        clear_mon();
        por_pin_n = 1'b1;
        idle(8);
        check(n_start == 1, "R1 start count", n_start, 1);
        check(last_kind == 2'b00, "R1 kind", last_kind, 0);
        check(cpu_rst_n && periph_rst_n && port_rst_n, "R1 released",
              {cpu_rst_n, periph_rst_n, port_rst_n}, 7);

        // Vector table: manual pin pulses (R6 R7 R8 R9 R10).
        for (int v = 0; v < 8; v++) begin
            int minq, steps;
            bit enter;
            minq  = VECS[v].stby ? int'(VECS[v].scnt) : 20;
            enter = (int'(VECS[v].low_len) >= minq) && (VECS[v].busy_len < VECS[v].low_len);
            steps = (VECS[v].low_len > VECS[v].busy_len) ? int'(VECS[v].low_len) : int'(VECS[v].busy_len);
            standby    = VECS[v].stby;
            settle_cnt = VECS[v].scnt;
            clear_mon();
            @(negedge clk);
            mrst_pin_n = 1'b0;
            bus_busy   = (VECS[v].busy_len != 0);
            for (int i = 1; i <= steps; i++) begin
                @(negedge clk);
                if (i == int'(VECS[v].low_len))  mrst_pin_n = 1'b1;
                if (i == int'(VECS[v].busy_len)) bus_busy = 1'b0;
            end
            mrst_pin_n = 1'b1;
            bus_busy   = 1'b0;
            idle(12);
            check((n_cpu > 0) == enter, $sformatf("R6/R7/R8 vec%0d entry", v), n_cpu > 0, enter);
            check(n_per == 0 && n_port == 0, $sformatf("R9 vec%0d other domains", v), n_per + n_port, 0);
            check(n_start == int'(enter), $sformatf("R10 vec%0d start count", v), n_start, enter);
            if (enter)
                check(last_kind == 2'b10, $sformatf("R10 vec%0d kind", v), last_kind, 2);
        end
        standby = 1'b0;

        // R3: overflow without configuration is ignored.
        clear_mon();
        wdt_por_en = 1'b0;
        pulse_wdt();
        idle(15);
        check(n_cpu == 0 && n_per == 0 && n_start == 0, "R3 no reset", n_cpu + n_per + n_start, 0);
        check(wdt_flag == 1'b0, "R3 flag untouched", wdt_flag, 0);

        // R2 R4: configured overflow.
        clear_mon();
        wdt_por_en = 1'b1;
        pulse_wdt();
        idle(15);
        check(n_cpu == HOLD && n_per == HOLD, "R2 hold length", n_cpu, HOLD);
        check(n_port == 0, "R2 port untouched", n_port, 0);
        check(n_start == 1 && last_kind == 2'b01, "R2 kind", last_kind, 1);
        check(wdt_flag == 1'b1, "R4 flag survives", wdt_flag, 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        idle(1);
        check(wdt_flag == 1'b0, "R4 flag cleared", wdt_flag, 0);

        // R5: pin reset together with overflow, flag set beforehand.
        pulse_wdt();
        idle(15);
        check(wdt_flag == 1'b1, "R5 flag preset", wdt_flag, 1);
        clear_mon();
        @(negedge clk);
        por_pin_n = 1'b0;
        wdt_ovf   = 1'b1;
        idle(4);
        wdt_ovf = 1'b0;
        idle(2);
        check(wdt_flag == 1'b0, "R5 flag cleared", wdt_flag, 0);
        por_pin_n = 1'b1;
        idle(8);
        check(n_port > 0, "R5 port reset", n_port, 1);
        check(n_start == 1 && last_kind == 2'b00, "R5 kind", last_kind, 0);

        // R12: overflow during a manual reset.
        clear_mon();
        @(negedge clk); mrst_pin_n = 1'b0;
        idle(26);
        check(cpu_rst_n == 1'b0 && periph_rst_n == 1'b1, "R12 manual active",
              {cpu_rst_n, periph_rst_n}, 1);
        @(negedge clk);
        wdt_ovf    = 1'b1;
        mrst_pin_n = 1'b1;
        @(negedge clk); wdt_ovf = 1'b0;
        idle(15);
        check(n_per == HOLD, "R12 peripherals reset", n_per, HOLD);
        check(n_start == 1 && first_kind == 2'b01, "R12 kind", first_kind, 1);
        check(wdt_flag == 1'b1, "R12 flag", wdt_flag, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule